// File: doc/BRIEF.md
# Undervoltage Trip Timer with Reset Hold

This block decides when an undervoltage protection stage trips. The measurement front end runs the threshold comparisons and the inverse-curve arithmetic. On each sample strobe it hands this block three inputs: a flag saying the voltage is under the pick-up level, a flag saying the voltage has recovered above the reset level, and an unsigned increment. The increment is the amount the inverse-time integrator should advance on that sample.

A two-bit mode selects one of three behaviours. The stage can be disabled. It can trip after a fixed number of consecutive undervoltage samples. Or it can trip when an integrator reaches its operate level. In inverse-time mode a short dip that does not trip leaves partial progress in the integrator. A programmable reset delay can keep that progress frozen for some recovery samples before it is cleared. A dip that returns within that window therefore trips sooner. Once the stage has actually tripped, recovery always clears everything at once. A block input silences the stage. An instant-trip input forces the trip output in either active mode.

Top module: `uv_trip_timer`

## Requirements
- R1: The mode code 2'b00 (disabled) and the spare code 2'b11 never assert the trip output, and the instant-trip input has no effect under them. Code 2'b01 selects definite time and 2'b10 selects inverse time.
- R2: In definite-time mode, the trip output rises on the clock after the N-th consecutive strobe with the undervoltage flag set, where N is the pick-up delay (a delay of 0 acts as 1). A strobe without the undervoltage flag restarts the count.
- R3: In inverse-time mode, each strobe with the undervoltage flag adds the increment to the integrator. The trip output rises on the clock after the strobe on which the sum reaches the operate level.
- R4: While the block input is high, the trip output is low from the next clock on and all timing state is cleared. After release, a full pick-up time is needed again.
- R5: In either active mode, the instant-trip input raises the trip output on the next clock, whether or not a strobe is present.
- R6: In inverse-time mode with a reset delay of 0, the first recovery strobe after a non-tripping dip clears the integrator.
- R7: The integrator saturates at the operate level and never exceeds it, even for increments far larger than the remaining distance.
- R8: With a reset delay of D greater than 0, the integrator keeps its value across D recovery strobes after a non-tripping dip and is cleared on the strobe after those D.
- R9: An undervoltage strobe during the hold abandons the hold count. Integration resumes from the frozen value, and a later recovery starts a fresh hold of D strobes.
- R10: While tripped, a strobe with the recovery flag set and the undervoltage flag clear drops the trip output on the next clock and clears the integrator, whatever the reset delay.
- R11: The trip output is a level. It stays high across undervoltage strobes, across clocks without a strobe, and across strobes where neither flag is set. Such neither-flag strobes also leave the timing state unchanged.
- R12: A synchronous reset clears the trip output and all timing state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleStb | input | 1 | One-cycle strobe marking a new sample |
| uvDetect | input | 1 | Voltage below pick-up level on this sample |
| aboveReset | input | 1 | Voltage above reset level on this sample |
| incr | input | INC_W | Inverse-time integrator increment for this sample |
| mode | input | 2 | 00 off, 01 definite time, 10 inverse time, 11 off |
| pickupDelay | input | CNT_W | Definite-time pick-up delay in strobes |
| resetDelay | input | CNT_W | Inverse-time reset hold in strobes |
| blockIn | input | 1 | Suppresses trip and timing |
| instTrip | input | 1 | Forces trip in an active mode |
| trip | output | 1 | Trip output, a level |

## Verification
On every cycle the assertions check the following. The disabled codes keep trip low. Block and a recovery while tripped drop trip on the next clock. Instant trip raises it. The integrator never passes the operate level. A hold strobe leaves the integrator untouched, and a clear strobe empties it. The bench scenarios alone can show that trip timing is right: the exact strobe on which pick-up or operate is reached, the length of the reset hold, and how progress resumes after an interrupted hold. Each of these appears only as an earlier or later trip several strobes downstream.

// File: rtl/uv_trip_pkg.sv
package uv_trip_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_DT    = 2'b01,
    MODE_IDMT  = 2'b10,
    MODE_SPARE = 2'b11
  } uvMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic cntInc;
    logic cntClr;
    logic intAcc;
    logic intClr;
    logic holdInc;
    logic holdClr;
  } uvStrobe_t;

endpackage

// File: rtl/uv_trip_datapath.sv
module uv_trip_datapath
  import uv_trip_pkg::*;
#(
  parameter int INC_W = 16,
  parameter int INT_W = 24,
  parameter int CNT_W = 16,
  parameter int unsigned OPERATE_LVL = 1_000_000
) (
  input  logic             clk,
  input  logic             rst,
  input  uvStrobe_t        strb,
  input  logic [INC_W-1:0] incr,
  input  logic [CNT_W-1:0] pickupDelay,
  input  logic [CNT_W-1:0] resetDelay,
  output logic             pickupDone,
  output logic             opReach,
  output logic             holdDone
);

  localparam int SUM_W = INT_W + 1;
  localparam logic [SUM_W-1:0] OP_EXT = SUM_W'(OPERATE_LVL);
  localparam logic [INT_W-1:0] OP_LVL = OP_EXT[INT_W-1:0];

  logic [CNT_W-1:0] pickCnt;
  logic [CNT_W-1:0] holdCnt;
  logic [INT_W-1:0] integ;
  logic [CNT_W:0]   pickPlus;
  logic [SUM_W-1:0] sumW;

  // Definite-time pick-up counter
  assign pickPlus   = {1'b0, pickCnt} + 1'b1;
  assign pickupDone = pickPlus >= {1'b0, pickupDelay};

  always_ff @(posedge clk) begin
    if (rst || strb.cntClr) pickCnt <= '0;
    else if (strb.cntInc && !(&pickCnt)) pickCnt <= pickCnt + 1'b1;
  end

  // Inverse-time integrator, saturating at the operate level
  assign sumW    = {1'b0, integ} + SUM_W'(incr);
  assign opReach = sumW >= OP_EXT;

  always_ff @(posedge clk) begin
    if (rst || strb.intClr) integ <= '0;
    else if (strb.intAcc) integ <= opReach ? OP_LVL : sumW[INT_W-1:0];
  end

  // Reset hold counter
  assign holdDone = holdCnt == resetDelay;

  always_ff @(posedge clk) begin
    if (rst || strb.holdClr) holdCnt <= '0;
    else if (strb.holdInc && !(&holdCnt)) holdCnt <= holdCnt + 1'b1;
  end

  AST_INT_CAPPED: assert property (@(posedge clk) disable iff (rst)
    integ <= OP_LVL); // R7
  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (rst)
    strb.holdInc && !strb.intClr |=> $stable(integ)); // R8
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    strb.intClr |=> integ == '0); // R6

endmodule

// File: rtl/uv_trip_ctrl.sv
module uv_trip_ctrl
  import uv_trip_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sampleStb,
  input  logic       uvDetect,
  input  logic       aboveReset,
  input  logic [1:0] mode,
  input  logic       blockIn,
  input  logic       instTrip,
  input  logic       pickupDone,
  input  logic       opReach,
  input  logic       holdDone,
  output uvStrobe_t  strb,
  output logic       trip
);

  uvMode_e modeE;
  logic    active;
  logic    tripNext;

  assign modeE  = uvMode_e'(mode);
  assign active = !blockIn && (modeE == MODE_DT || modeE == MODE_IDMT);

  always_comb begin
    strb     = '0;
    tripNext = trip;
    if (!active) begin
      strb.cntClr  = 1'b1;
      strb.intClr  = 1'b1;
      strb.holdClr = 1'b1;
      tripNext     = 1'b0;
    end else begin
      if (sampleStb) begin
        if (trip) begin
          // after a trip recovery is always immediate
          if (aboveReset && !uvDetect) begin
            tripNext     = 1'b0;
            strb.cntClr  = 1'b1;
            strb.intClr  = 1'b1;
            strb.holdClr = 1'b1;
          end
        end else if (modeE == MODE_DT) begin
          strb.intClr  = 1'b1;
          strb.holdClr = 1'b1;
          if (uvDetect) begin
            strb.cntInc = 1'b1;
            if (pickupDone) tripNext = 1'b1;
          end else begin
            strb.cntClr = 1'b1;
          end
        end else begin
          strb.cntClr = 1'b1;
          if (uvDetect) begin
            strb.intAcc  = 1'b1;
            strb.holdClr = 1'b1;
            if (opReach) tripNext = 1'b1;
          end else if (aboveReset) begin
            if (holdDone) begin
              strb.intClr  = 1'b1;
              strb.holdClr = 1'b1;
            end else begin
              strb.holdInc = 1'b1;
            end
          end
        end
      end
      if (instTrip) tripNext = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) trip <= 1'b0;
    else     trip <= tripNext;
  end

  AST_OFF_NO_TRIP: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00 || mode == 2'b11) |=> !trip); // R1
  AST_BLOCK_DROPS: assert property (@(posedge clk) disable iff (rst)
    blockIn |=> !trip); // R4
  AST_INST_FORCES: assert property (@(posedge clk) disable iff (rst)
    instTrip && !blockIn && (mode == 2'b01 || mode == 2'b10) |=> trip); // R5
  AST_TRIP_RESET_IMMED: assert property (@(posedge clk) disable iff (rst)
    trip && sampleStb && aboveReset && !uvDetect && !instTrip |=> !trip); // R10

endmodule

// File: rtl/uv_trip_timer.sv
module uv_trip_timer
  import uv_trip_pkg::*;
#(
  parameter int INC_W = 16,
  parameter int INT_W = 24,
  parameter int CNT_W = 16,
  parameter int unsigned OPERATE_LVL = 1_000_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sampleStb,
  input  logic             uvDetect,
  input  logic             aboveReset,
  input  logic [INC_W-1:0] incr,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] pickupDelay,
  input  logic [CNT_W-1:0] resetDelay,
  input  logic             blockIn,
  input  logic             instTrip,
  output logic             trip
);

  uvStrobe_t strb;
  logic      pickupDone;
  logic      opReach;
  logic      holdDone;

  uv_trip_ctrl ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .sampleStb  (sampleStb),
    .uvDetect   (uvDetect),
    .aboveReset (aboveReset),
    .mode       (mode),
    .blockIn    (blockIn),
    .instTrip   (instTrip),
    .pickupDone (pickupDone),
    .opReach    (opReach),
    .holdDone   (holdDone),
    .strb       (strb),
    .trip       (trip)
  );

  uv_trip_datapath #(
    .INC_W       (INC_W),
    .INT_W       (INT_W),
    .CNT_W       (CNT_W),
    .OPERATE_LVL (OPERATE_LVL)
  ) dp_i (
    .clk         (clk),
    .rst         (rst),
    .strb        (strb),
    .incr        (incr),
    .pickupDelay (pickupDelay),
    .resetDelay  (resetDelay),
    .pickupDone  (pickupDone),
    .opReach     (opReach),
    .holdDone    (holdDone)
  );

endmodule

// File: tb/uv_trip_timer_tb.sv
module uv_trip_timer_tb_top;

  localparam int INC_W = 16;
  localparam int CNT_W = 8;
  localparam int unsigned OP = 1000;

  typedef struct packed {
    logic [1:0]  mode;
    logic        blk;
    logic        inst;
    logic        stb;
    logic        uv;
    logic        abv;
    logic [15:0] incr;
    logic [3:0]  pd;
    logic [3:0]  rd;
    logic        exp;
    logic [3:0]  req;
  } row_t;

  function automatic row_t mk(input logic [1:0] m, input logic b, input logic it,
                              input logic s, input logic u, input logic a,
                              input logic [15:0] inc, input logic [3:0] p,
                              input logic [3:0] r, input logic e, input logic [3:0] q);
    row_t t;
    t = '{mode: m, blk: b, inst: it, stb: s, uv: u, abv: a, incr: inc,
          pd: p, rd: r, exp: e, req: q};
    return t;
  endfunction

  localparam int NROWS = 61;
  //        mode blk inst stb uv abv incr  pd rd exp req
  localparam row_t TBL [NROWS] = '{
    mk(1,0,0,1,1,0,    0,3,0,0, 2), // R2 uv 1
    mk(1,0,0,1,1,0,    0,3,0,0, 2), // R2 uv 2
    mk(1,0,0,1,1,0,    0,3,0,1, 2), // R2 uv 3 trips
    mk(1,0,0,1,1,0,    0,3,0,1,11), // R11 held under uv
    mk(1,0,0,0,0,1,    0,3,0,1,11), // R11 no strobe
    mk(1,0,0,1,0,0,    0,3,0,1,11), // R11 band strobe
    mk(1,0,0,1,0,1,    0,3,0,0,10), // R10 recovery
    mk(1,0,0,1,1,0,    0,3,0,0, 2), // R2 uv 1
    mk(1,0,0,1,0,0,    0,3,0,0, 2), // R2 break restarts
    mk(1,0,0,1,1,0,    0,3,0,0, 2),
    mk(1,0,0,1,1,0,    0,3,0,0, 2),
    mk(1,0,0,1,1,0,    0,3,0,1, 2), // R2 full count again
    mk(1,0,0,1,0,1,    0,3,0,0,10),
    mk(1,0,0,1,1,0,    0,3,0,0, 4),
    mk(1,0,0,1,1,0,    0,3,0,0, 4),
    mk(1,1,0,1,1,0,    0,3,0,0, 4), // R4 block clears count
    mk(1,0,0,1,1,0,    0,3,0,0, 4),
    mk(1,0,0,1,1,0,    0,3,0,0, 4),
    mk(1,0,0,1,1,0,    0,3,0,1, 4), // R4 full pick-up needed
    mk(1,1,0,0,1,0,    0,3,0,0, 4), // R4 block drops trip
    mk(1,0,0,1,0,1,    0,3,0,0,10),
    mk(0,0,0,1,1,0,    0,1,0,0, 1), // R1 off
    mk(0,0,1,1,1,0,    0,1,0,0, 5), // R5 instant ignored when off
    mk(3,0,1,1,1,0,    0,1,0,0, 1), // R1 spare code
    mk(1,0,1,0,0,0,    0,3,0,1, 5), // R5 instant in DT
    mk(1,0,0,1,0,1,    0,3,0,0,10),
    mk(2,0,0,1,1,0,  300,0,0,0, 3), // 300
    mk(2,0,0,1,1,0,  300,0,0,0, 3), // 600
    mk(2,0,0,1,1,0,  300,0,0,0, 3), // 900
    mk(2,0,0,1,0,1,    0,0,0,0, 6), // R6 clears at once
    mk(2,0,0,1,1,0,  100,0,0,0, 6), // R6 100 only
    mk(2,0,0,1,1,0,  300,0,0,0, 3), // 400
    mk(2,0,0,1,1,0,  600,0,0,1, 3), // R3 reaches 1000
    mk(2,0,0,1,0,1,    0,0,0,0,10),
    mk(2,0,0,1,1,0,  300,0,2,0, 8),
    mk(2,0,0,1,1,0,  300,0,2,0, 8),
    mk(2,0,0,1,1,0,  300,0,2,0, 8), // 900
    mk(2,0,0,1,0,1,    0,0,2,0, 8), // R8 hold 1
    mk(2,0,0,1,0,1,    0,0,2,0, 8), // R8 hold 2
    mk(2,0,0,1,1,0,  100,0,2,1, 8), // R8 frozen 900 + 100
    mk(2,0,0,1,0,1,    0,0,2,0,10), // R10 immediate despite delay
    mk(2,0,0,1,1,0,  900,0,2,0,10), // R10 integrator was empty
    mk(2,0,0,1,0,1,    0,0,2,0, 8),
    mk(2,0,0,1,0,1,    0,0,2,0, 8),
    mk(2,0,0,1,0,1,    0,0,2,0, 8), // R8 third recovery clears
    mk(2,0,0,1,1,0,  100,0,2,0, 8), // R8 100
    mk(2,0,0,1,1,0,  899,0,2,0, 3), // 999
    mk(2,0,0,1,1,0,    1,0,2,1, 3), // R3 exact boundary
    mk(2,0,0,1,0,1,    0,0,2,0,10),
    mk(2,0,0,1,1,0,  500,0,3,0, 9), // 500
    mk(2,0,0,1,0,1,    0,0,3,0, 9), // hold 1
    mk(2,0,0,1,1,0,  200,0,3,0, 9), // R9 resume 700
    mk(2,0,0,1,0,1,    0,0,3,0, 9),
    mk(2,0,0,1,0,1,    0,0,3,0, 9),
    mk(2,0,0,1,0,1,    0,0,3,0, 9), // R9 fresh hold of 3
    mk(2,0,0,1,1,0,  300,0,3,1, 9), // R9 700 + 300 trips
    mk(2,0,0,1,0,1,    0,0,3,0,10),
    mk(2,0,0,1,1,0,65535,0,0,1, 7), // R7 saturating trip
    mk(2,0,0,1,0,1,    0,0,0,0,10),
    mk(2,0,0,1,1,0,  999,0,0,0, 7), // R7 no residue
    mk(2,0,0,1,1,0,    1,0,0,1, 7)
  };

  logic             clk = 1'b0;
  logic             rst;
  logic             sampleStb, uvDetect, aboveReset, blockIn, instTrip;
  logic [INC_W-1:0] incr;
  logic [1:0]       mode;
  logic [CNT_W-1:0] pickupDelay, resetDelay;
  logic             trip;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  uv_trip_timer #(
    .INC_W(INC_W), .INT_W(24), .CNT_W(CNT_W), .OPERATE_LVL(OP)
  ) dut_i (
    .clk(clk), .rst(rst), .sampleStb(sampleStb), .uvDetect(uvDetect),
    .aboveReset(aboveReset), .incr(incr), .mode(mode),
    .pickupDelay(pickupDelay), .resetDelay(resetDelay),
    .blockIn(blockIn), .instTrip(instTrip), .trip(trip)
  );

  task automatic check(input logic expv, input int req, input int idx);
    testsRun++;
    if (trip !== expv) begin
      testsFailed++;
      $display("FAIL R%0d step %0d: trip=%0b expected %0b", req, idx, trip, expv);
    end
  endtask

  task automatic drive(input row_t r);
    mode        = r.mode;
    blockIn     = r.blk;
    instTrip    = r.inst;
    sampleStb   = r.stb;
    uvDetect    = r.uv;
    aboveReset  = r.abv;
    incr        = r.incr;
    pickupDelay = CNT_W'(r.pd);
    resetDelay  = CNT_W'(r.rd);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: run hung, trip=%0b expected completion", trip);
    finish_run();
  end

  initial begin
    rst = 1'b1;
    drive(mk(1,0,0,1,1,0,0,3,0,0,12));
    repeat (3) @(negedge clk);
    check(1'b0, 12, -1); // R12 reset state
    rst = 1'b0;

    for (int i = 0; i < NROWS; i++) begin
      drive(TBL[i]);
      @(negedge clk);
      check(TBL[i].exp, int'(TBL[i].req), i);
    end

    // R12: reset mid-count restarts the pick-up
    drive(mk(1,0,0,1,1,0,0,3,0,0,12));
    @(negedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk); check(1'b0, 12, 100);
    @(negedge clk); check(1'b0, 12, 101);
    @(negedge clk); check(1'b1, 12, 102);
    // R12: reset drops an active trip
    rst = 1'b1;
    @(negedge clk); check(1'b0, 12, 103);
    rst = 1'b0;
    drive(mk(1,0,0,0,0,0,0,3,0,0,12));
    @(negedge clk); check(1'b0, 12, 104);

    finish_run();
  end

endmodule